// File: doc/BRIEF.md
# Chopped Third-Order Sinc Decimation Controller

This block turns the one-bit output of an external delta-sigma modulator into signed 24-bit conversion results. It runs a third-order sinc (cascaded integrator-comb) decimator under a chopping schedule. A swap output reverses the polarity of the analog input ahead of the modulator. Each polarity phase lets the filter settle over three decimation periods and then captures one settled conversion. Before the next phase starts, the swap output flips and the filter state is cleared.

The conversion taken with reversed polarity is negated. It is then averaged with the conversion from the phase before, so a constant offset in the modulator path cancels while the wanted signal stays. A 10-bit rate word `rate` sets the decimation ratio. A `restart` pulse, issued by the surrounding logic on a channel change, clears the filter and the chop sequence exactly as reset does.

Top module: `chop_sinc3_ctrl`

## Requirements
- R1: After reset or `restart`, `swap` is 0. It then inverts at the end of every phase of 3072·FS master clocks, where FS is the effective rate word. During reset, `data_valid` and `data_out` are 0.
- R2: The block samples `mod_bit` once every 16 master clocks, mapping 1 to +1 and 0 to −1. It applies a sinc3 decimator of ratio 64·FS on these samples. A phase conversion is the settled sinc3 sum shifted right arithmetically by SHIFT = 3·clog2(64·MAX_RATE)+2−24 bits.
- R3: Each output is the mean (arithmetic right shift by one) of the last two phase conversions, with the conversion taken while `swap` = 1 negated first. Suppose every 4 consecutive samples carry n ones while `swap` = 0 and m ones while `swap` = 1. Then the output is (64·FS)³·(n−m)/2^(SHIFT+2).
- R4: Adding the same density offset to both polarities does not change the output.
- R5: After reset is released, or after the clock edge that samples `restart`, the first `data_valid` comes exactly 2·3072·FS clocks later.
- R6: After that first output, `data_valid` repeats every 3072·FS clocks.
- R7: `data_valid` lasts exactly one clock. `data_out` holds its value between pulses.
- R8: A rate word of 0 behaves as a rate word of 1.
- R9: A step in the input density raises no flag. Outputs keep their spacing, and the third output after the step shows the new settled value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Channel-change request, restarts filter and chop sequence |
| rate | input | 10 | Rate word FS (0 treated as 1) |
| mod_bit | input | 1 | Modulator bitstream |
| swap | output | 1 | Input polarity reversal control |
| data_out | output | 24 | Averaged signed conversion result |
| data_valid | output | 1 | One-clock strobe for a new result |

## Verification
The bound checker watches the cycle-level rules on every clock:
- each strobe is a single clock wide and coincides with a polarity inversion;
- the result register changes only when a new result is strobed;
- a restart leaves the block with no strobe and normal polarity.

The numeric rules need the bench's scenarios:
- offset cancellation and the averaged value under several density pairs and rate words;
- the exact latency to the first output after reset or restart;
- output spacing;
- settling after a step in the input.

// File: rtl/chop_sinc3_ctrl.sv
module chop_sinc3_ctrl #(
  parameter int MAX_RATE = 1023,
  parameter int OUT_W    = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [9:0]       rate,
  input  logic             mod_bit,
  output logic             swap,
  output logic [OUT_W-1:0] data_out,
  output logic             data_valid
);
  localparam int LOG_R = $clog2(64 * MAX_RATE);
  localparam int ACC_W = 3 * LOG_R + 2;
  localparam int SHIFT = ACC_W - OUT_W;

  logic [3:0]              div;
  logic [LOG_R-1:0]        ce_cnt;
  logic [1:0]              dec_cnt;
  logic [9:0]              fs_q;
  logic                    have_prev;
  logic signed [ACC_W-1:0] i1, i2, i3, d1, d2, d3;
  logic signed [OUT_W:0]   prev;

  wire [9:0]  fs_in = (rate == 10'd0) ? 10'd1 : rate;
  wire [15:0] r_m1  = {fs_q, 6'd0} - 16'd1;
  wire        ce    = (div == 4'hF);
  wire        dec_end   = ce && (16'(ce_cnt) == r_m1);
  wire        phase_end = dec_end && (dec_cnt == 2'd2);

  wire signed [ACC_W-1:0] x   = {{(ACC_W-1){~mod_bit}}, 1'b1};
  wire signed [ACC_W-1:0] i1n = i1 + x;
  wire signed [ACC_W-1:0] i2n = i2 + i1n;
  wire signed [ACC_W-1:0] i3n = i3 + i2n;
  wire signed [ACC_W-1:0] c1  = i3n - d1;
  wire signed [ACC_W-1:0] c2  = c1 - d2;
  wire signed [ACC_W-1:0] c3  = c2 - d3;

  wire signed [ACC_W-1:0] c3s    = c3 >>> SHIFT;
  wire signed [OUT_W-1:0] conv   = OUT_W'(c3s);
  wire signed [OUT_W:0]   conv_x = {conv[OUT_W-1], conv};
  wire signed [OUT_W:0]   corr   = swap ? -conv_x : conv_x;
  wire signed [OUT_W+1:0] sum    = {prev[OUT_W], prev} + {corr[OUT_W], corr};
  wire signed [OUT_W:0]   avg    = sum[OUT_W+1:1];
  wire [OUT_W-1:0]        sat    = (avg[OUT_W] != avg[OUT_W-1]) ?
                                   {avg[OUT_W], {(OUT_W-1){~avg[OUT_W]}}} : avg[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div        <= '0;
      ce_cnt     <= '0;
      dec_cnt    <= '0;
      fs_q       <= fs_in;
      have_prev  <= 1'b0;
      swap       <= 1'b0;
      data_valid <= 1'b0;
      prev       <= '0;
      {i1, i2, i3} <= '0;
      {d1, d2, d3} <= '0;
      if (rst) data_out <= '0;
    end else begin
      div        <= div + 4'd1;
      data_valid <= 1'b0;
      if (ce) begin
        if (phase_end) begin
          {i1, i2, i3} <= '0;
          {d1, d2, d3} <= '0;
          ce_cnt    <= '0;
          dec_cnt   <= '0;
          swap      <= ~swap;
          prev      <= corr;
          have_prev <= 1'b1;
          fs_q      <= fs_in;
          if (have_prev) begin
            data_out   <= sat;
            data_valid <= 1'b1;
          end
        end else begin
          i1 <= i1n;
          i2 <= i2n;
          i3 <= i3n;
          if (dec_end) begin
            d1      <= i3n;
            d2      <= c1;
            d3      <= c2;
            ce_cnt  <= '0;
            dec_cnt <= dec_cnt + 2'd1;
          end else begin
            ce_cnt <= ce_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/chop_sinc3_ctrl_chk.sv
module chop_sinc3_ctrl_chk #(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             restart,
  input logic             swap,
  input logic [OUT_W-1:0] data_out,
  input logic             data_valid
);
  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> !data_valid);

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !data_valid |-> $stable(data_out));

  // R1
  valid_on_swap_chk: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> (swap != $past(swap)));

  // R5
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!data_valid && !swap));
endmodule

bind chop_sinc3_ctrl chop_sinc3_ctrl_chk #(.OUT_W(OUT_W)) u_chk (.*);

// File: tb/chop_sinc3_ctrl_test.sv
`timescale 1ns/1ps
module chop_sinc3_ctrl_test;
  localparam int MAXR = 4;
  localparam int ACCW = 3 * $clog2(64 * MAXR) + 2;
  localparam longint DIVISOR = longint'(1) << (ACCW - 24 + 2);
  localparam int NV = 7;
  localparam int VEC [NV][3] = '{
    '{1, 3, 2}, '{1, 2, 1}, '{1, 4, 4}, '{1, 4, 0},
    '{2, 1, 3}, '{0, 4, 0}, '{4, 3, 2}
  };

  logic clk = 0, rst = 1, restart = 0, mod_bit = 0;
  logic [9:0] rate = 10'd1;
  logic swap, data_valid;
  logic [23:0] data_out;
  int checks = 0, errors = 0;
  int kn = 4, ki = 0;
  longint cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) mod_bit <= ({30'd0, cyc[5:4]} < (swap ? ki : kn));

  chop_sinc3_ctrl #(.MAX_RATE(MAXR)) uut (
    .clk(clk), .rst(rst), .restart(restart), .rate(rate), .mod_bit(mod_bit),
    .swap(swap), .data_out(data_out), .data_valid(data_valid));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint expv(input int fs, input int n, input int m);
    longint r = 64 * ((fs == 0) ? 1 : fs);
    return r * r * r * (n - m) / DIVISOR;
  endfunction

  function automatic longint dout();
    return longint'($signed(data_out));
  endfunction

  // Waits for the next strobe, returns edges counted from call.
  task automatic wait_valid(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); @(negedge clk);
      if (data_valid) begin n = i; return; end
    end
  endtask

  task automatic run_vec(input int fs, input int n, input int m);
    int p = 3072 * ((fs == 0) ? 1 : fs);
    int first = -1, nval = 0;
    longint e = expv(fs, n, m);
    @(negedge clk);
    rate = 10'(fs); kn = n; ki = m; restart = 1;
    @(posedge clk); @(negedge clk);
    restart = 0;
    for (int i = 1; i <= 3 * p + 4 && nval < 2; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 1) chk(swap == 1'b0, "R1 swap after restart", swap, 0);
      if (i == p) chk(swap == 1'b1, "R1 swap after one phase", swap, 1);
      if (data_valid) begin
        if (first < 0) begin
          first = i;
          chk(i == 2 * p, "R5 first latency", i, 2 * p);
          if (fs == 0) chk(i == 2 * 3072, "R8 rate zero as one", i, 2 * 3072);
        end else begin
          chk(i == first + p, "R6 output spacing", i - first, p);
        end
        chk(dout() == e, (n - m == 0) ? "R4 offset cancel" : "R3 averaged value", dout(), e);
        nval++;
      end
    end
    chk(nval == 2, "R6 outputs seen", nval, 2);
  endtask

  initial begin
    int n;
    rate = 10'd1; kn = 4; ki = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(data_valid == 0, "R1 reset valid", data_valid, 0);
    chk(swap == 0, "R1 reset swap", swap, 0);
    chk(data_out == 0, "R1 reset data", dout(), 0);
    rst = 0;
    wait_valid(2 * 3072 + 8, n);
    chk(n == 2 * 3072, "R5 latency after reset", n, 2 * 3072);
    chk(dout() == expv(1, 4, 0), "R2 full-scale conversion", dout(), expv(1, 4, 0));
    @(posedge clk); @(negedge clk);
    chk(data_valid == 0, "R7 single-cycle strobe", data_valid, 0);
    repeat (1000) @(posedge clk);
    @(negedge clk);
    chk(dout() == expv(1, 4, 0), "R7 data held", dout(), expv(1, 4, 0));

    for (int v = 0; v < NV; v++) run_vec(VEC[v][0], VEC[v][1], VEC[v][2]);

    // Step in input density mid-phase, no restart.
    run_vec(1, 4, 0);
    repeat (1500) @(posedge clk);
    @(negedge clk);
    kn = 1; ki = 3;
    wait_valid(3072 + 8, n);
    for (int k = 2; k <= 3; k++) begin
      wait_valid(3072 + 8, n);
      chk(n == 3072, "R9 spacing kept after step", n, 3072);
    end
    chk(dout() == expv(1, 1, 3), "R9 settled after step", dout(), expv(1, 1, 3));

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule